// File: doc/BRIEF.md
# Single-Pulse Correspondence Monitor

This block watches a one-bit level signal and a one-bit pulse signal. It checks, cycle by cycle, that every rising edge of the level is matched by exactly one output pulse, and that every pulse is matched by exactly one edge.

It holds a registered copy of the level to find rising edges, and it records whether an edge is still waiting for its pulse. It raises one of three sticky error flags when a check breaks:

- an extra or stretched pulse;
- an extra edge;
- an edge left waiting too long.

True liveness cannot be settled in a finite run, so a parameterised wait limit stands in for it. A mask input turns that limit off for stimulus where the level may stay high on purpose.

A reference pulser is built in. It fires in the cycle the level falls, and it is the default pulse source being monitored. A parameter switches the monitor to an external pulse input instead, so that any other single-pulser design can be checked.

Top module: `pulse_pair_monitor`

## Requirements
- R1: A rising edge is a cycle in which `lvl` is 1 and the registered previous `lvl` is 0. Reset clears the previous value to 0, so a 1 on `lvl` in the first cycle after reset is an edge.
- R2: `ref_pls` is 1 in exactly those cycles where the previous `lvl` is 1 and the current `lvl` is 0. It is combinational in the current `lvl`, and it is 0 in the first cycle after reset.
- R3: A monitored pulse sets `err_multi_pulse` at the clock edge closing that cycle in either of two cases: the pulse was also high in the previous cycle, or no rising edge has occurred since the previous pulse (counting the current cycle; after reset there is no previous pulse).
- R4: A rising edge in a cycle with no monitored pulse, while an earlier edge is still unanswered, sets `err_multi_edge` at the closing clock edge.
- R5: A monitored pulse in the same cycle as a rising edge answers that edge at once. Nothing is left pending, and no error results.
- R6: If an edge at cycle e is still unanswered in a cycle k with no pulse and k − e > `MAX_WAIT`, then `err_live` is set at the edge closing cycle k.
- R7: While `stuck_ok` is 1, the condition of R6 does not set `err_live`. The other two flags are unaffected by `stuck_ok`.
- R8: All three error flags are 0 after a synchronous active-high reset. Once set, each flag stays 1 until the next reset.
- R9: With `USE_REF` = 1, the monitored pulse is `ref_pls` and `pls_ext` has no effect. With `USE_REF` = 0, the monitored pulse is `pls_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lvl | input | 1 | Level signal whose rising edges are counted |
| pls_ext | input | 1 | External pulse to monitor when `USE_REF` = 0 |
| stuck_ok | input | 1 | Masks the wait-limit error when 1 |
| ref_pls | output | 1 | Reference falling-edge pulse |
| err_live | output | 1 | Sticky: an edge waited more than `MAX_WAIT` cycles |
| err_multi_pulse | output | 1 | Sticky: pulse without a fresh edge, or pulse longer than one cycle |
| err_multi_edge | output | 1 | Sticky: second edge before the first was answered |

## Verification
An error flag is registered on the clock edge that closes the offending cycle. It is therefore readable one cycle after the stimulus that caused it.

`ref_pls` follows `lvl` within the same cycle, with no register on the way.

The bench drives each cycle's inputs at the falling clock edge. It reads the flags at the next falling edge, where the expected value covers every stimulus cycle up to the one just closed. It reads `ref_pls` a short delay after driving, in the same cycle.

The expected flags come from a scan over the stimulus arrays. The scan covers every pattern of level and external pulse over five cycles, with both mask settings.

// File: rtl/pulse_pair_monitor.sv
module pulse_pair_monitor #(
  parameter int MAX_WAIT = 8,
  parameter bit USE_REF  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic pls_ext,
  input  logic stuck_ok,
  output logic ref_pls,
  output logic err_live,
  output logic err_multi_pulse,
  output logic err_multi_edge
);
  localparam int CW = $clog2(MAX_WAIT + 2);
  localparam logic [CW-1:0] LIM = CW'(MAX_WAIT + 1);

  logic          lvl_q, mon_q, pending;
  logic [CW-1:0] wait_cnt;
  logic          mon, rise, pending_d;
  logic          bad_pulse, bad_edge, bad_live;

  assign ref_pls   = lvl_q & ~lvl;
  assign mon       = USE_REF ? ref_pls : pls_ext;
  assign rise      = lvl & ~lvl_q;
  assign pending_d = ~mon & (pending | rise);

  assign bad_pulse = mon & (mon_q | ~(pending | rise));
  assign bad_edge  = rise & pending & ~mon;
  assign bad_live  = pending & ~mon & ~stuck_ok & (wait_cnt >= LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q           <= 1'b0;
      mon_q           <= 1'b0;
      pending         <= 1'b0;
      wait_cnt        <= '0;
      err_live        <= 1'b0;
      err_multi_pulse <= 1'b0;
      err_multi_edge  <= 1'b0;
    end else begin
      lvl_q   <= lvl;
      mon_q   <= mon;
      pending <= pending_d;
      if (!pending_d)          wait_cnt <= '0;
      else if (!pending)       wait_cnt <= CW'(1);
      else if (wait_cnt != LIM) wait_cnt <= wait_cnt + CW'(1);
      err_live        <= err_live | bad_live;
      err_multi_pulse <= err_multi_pulse | bad_pulse;
      err_multi_edge  <= err_multi_edge | bad_edge;
    end
  end

  assert_ref_falling_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_pls && !$past(rst)) |-> (!lvl && $past(lvl)));

  assert_two_cycle_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (mon && mon_q) |=> err_multi_pulse);

  assert_edge_on_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (rise && pending && !mon) |=> err_multi_edge);

  assert_pulse_clears_R5: assert property (@(posedge clk) disable iff (rst)
    mon |=> !pending);

  assert_mask_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (stuck_ok && !err_live) |=> !err_live);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_live) && $past(err_multi_pulse) == 1'b1) |-> (err_live && err_multi_pulse));

  assert_sticky_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_multi_edge)) |-> err_multi_edge);
endmodule

// File: tb/pulse_pair_monitor_tb_top.sv
`timescale 1ns/1ps
module pulse_pair_monitor_tb_top;
  localparam int L  = 5;
  localparam int MW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic lvl_a = 1'b0, pls_a = 1'b0, so_a = 1'b0;
  logic ref_a, el_a, ep_a, ee_a;
  logic lvl_b = 1'b0;
  logic ref_b, el_b, ep_b, ee_b;

  int checks = 0;
  int fails  = 0;

  logic lv [0:L-1];
  logic pl [0:L-1];

  pulse_pair_monitor #(.MAX_WAIT(MW), .USE_REF(1'b0)) dut_i (
    .clk(clk), .rst(rst), .lvl(lvl_a), .pls_ext(pls_a), .stuck_ok(so_a),
    .ref_pls(ref_a), .err_live(el_a), .err_multi_pulse(ep_a), .err_multi_edge(ee_a));

  pulse_pair_monitor #(.MAX_WAIT(4), .USE_REF(1'b1)) dut_r (
    .clk(clk), .rst(rst), .lvl(lvl_b), .pls_ext(1'b1), .stuck_ok(1'b1),
    .ref_pls(ref_b), .err_live(el_b), .err_multi_pulse(ep_b), .err_multi_edge(ee_b));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic reset_all();
    rst = 1'b1; lvl_a = 1'b0; pls_a = 1'b0; lvl_b = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: previous level is 0 after reset
  function automatic logic is_rise(input int k);
    if (k == 0) return lv[0];
    return lv[k] & ~lv[k-1];
  endfunction

  // returns {live, multi_pulse, multi_edge} for stimulus cycles 0..t
  function automatic logic [2:0] expect_upto(input int t, input logic so);
    logic el, emp, eme;
    int lp, first;
    el = 1'b0; emp = 1'b0; eme = 1'b0; lp = -1;
    for (int k = 0; k <= t; k++) begin
      first = -1;
      for (int r = lp + 1; r < k; r++)
        if (is_rise(r) && first < 0) first = r;
      if (pl[k]) begin
        // R5: edge in this cycle answers the pulse
        if ((k > 0 && pl[k-1]) || !(first >= 0 || is_rise(k))) emp = 1'b1;
        lp = k;
      end else begin
        if (is_rise(k) && first >= 0) eme = 1'b1;
        if (!so && first >= 0 && (k - first) > MW) el = 1'b1;
      end
    end
    return {el, emp, eme};
  endfunction

  initial begin
    logic [2:0] e;
    reset_all();
    chk("R8 reset err_live", el_a, 1'b0);
    chk("R8 reset err_multi_pulse", ep_a, 1'b0);
    chk("R8 reset err_multi_edge", ee_a, 1'b0);
    chk("R2 reset ref_pls", ref_b, 1'b0);

    for (int so = 0; so < 2; so++) begin
      for (int code = 0; code < (1 << (2*L)); code++) begin
        for (int k = 0; k < L; k++) begin
          lv[k] = code[2*k];
          pl[k] = code[2*k+1];
        end
        so_a = so[0];
        reset_all();
        for (int t = 0; t <= L; t++) begin
          if (t > 0) begin
            e = expect_upto(t - 1, so[0]);
            chk("R6 R7 err_live", el_a, e[2]);
            chk("R3 R8 err_multi_pulse", ep_a, e[1]);
            chk("R4 R8 err_multi_edge", ee_a, e[0]);
          end
          if (t < L) begin
            lvl_a = lv[t];
            pls_a = pl[t];
            @(negedge clk);
          end
        end
      end
    end

    for (int code = 0; code < 256; code++) begin
      reset_all();
      for (int t = 0; t < 8; t++) begin
        lvl_b = code[t];
        #1;
        chk("R2 ref_pls", ref_b, (t > 0 ? code[t-1] : 1'b0) & ~code[t]);
        @(negedge clk);
      end
      chk("R9 ext pulse ignored err_multi_pulse", ep_b, 1'b0);
      chk("R9 ref monitored err_multi_edge", ee_b, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule